// File: doc/BRIEF.md
# Watchdog Timer with Guarded Shutdown

This block counts clock cycles of an already divided system clock and, when software fails to service it within a programmable period, emits a one-cycle reset pulse to the rest of the system. Software services it by pulsing a restart strobe. A narrow control register selects the period and holds the run bit.

Starting the watchdog takes a single write. Stopping it is guarded so that a stray store cannot switch it off. Software must first write the register with both the run bit and an unlock bit set. It must then write the run bit back to zero within a short window of cycles. The unlock bit drops by itself when that window closes. The base period is set by a parameter, and each step of the 3-bit period code doubles it. The wall-clock timeout is the oscillator period times the upstream clock divider times the selected cycle count.

Top module: `wdt_guard`

## Requirements
- R1: After synchronous reset, `rd_data` reads 0 and `wdt_rst` is low. The watchdog is stopped with period code 000.
- R2: Control field positions, for both writes and reads: bit 4 is the unlock bit, bit 3 the run bit and bits [2:0] the period code. `rd_data` returns {unlock-window-open, run, code}.
- R3: A write with bit 3 set always starts the watchdog, whether or not it is running, and restarts the count from zero.
- R4: While running, the timeout period is 2^(LOG2_BASE+code) cycles. With the default LOG2_BASE = 11, that is 2,048 cycles for code 000 and 262,144 cycles for code 111. `wdt_rst` is high for exactly one cycle: the cycle after the edge that completes the period. Counting then restarts from zero.
- R5: A `kick` pulse clears the count. The next `wdt_rst` comes a full period after the kick edge, and no pulse is produced in the cycle after a kick.
- R6: A write with bits 4 and 3 both set opens a window. A write with bit 3 clear stops the watchdog if it lands on any of the four clock edges that follow the opening write.
- R7: A write with bit 3 clear is ignored when no window is open, for example on the fifth edge or later, or with no opening write at all. The run bit keeps reading 1.
- R8: The unlock bit reads 1 in the four cycles that start with the opening write and clears itself afterwards. It also clears at once when a stop write is accepted.
- R9: While stopped, `wdt_rst` never pulses, whatever the period code.
- R10: A write that changes the period code while the watchdog is running restarts the count. The new period is measured from that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divided system clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 5 | Write data: bit 4 unlock, bit 3 run, bits [2:0] period code |
| kick | input | 1 | Watchdog service strobe; clears the count |
| rd_data | output | 5 | Read-back: {window open, run, period code} |
| wdt_rst | output | 1 | One-cycle system reset pulse on timeout |

## Verification
The embedded properties check several rules on every cycle. The run bit may fall only while the unlock window is open. The window counter never exceeds its length and reloads after an opening write. The reset pulse lasts one cycle, only ever follows a running state and never follows a kick. The count never exceeds the current period. The exact timeout lengths for each period code, the edge-by-edge boundary of the stop window and the self-clearing of the unlock bit can only be shown by the bench's directed scenarios. The bench also runs a long random mix of writes, kicks and stop sequences against a cycle model.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int REG_W   = 5;
    localparam int CODE_W  = 3;
    localparam int RUN_BIT = 3;
    localparam int UNL_BIT = 4;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic  unlock;
        logic  run;
        code_t code;
    } ctrl_view_t;

    typedef enum logic [1:0] {
        CNT_CLEAR = 2'd0,
        CNT_STEP  = 2'd1,
        CNT_WRAP  = 2'd2
    } cnt_act_e;

    function automatic logic is_open_req(input logic [REG_W-1:0] d);
        return d[UNL_BIT] & d[RUN_BIT];
    endfunction

    function automatic logic is_stop_req(input logic [REG_W-1:0] d);
        return ~d[RUN_BIT];
    endfunction

endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
    import wdt_pkg::*;
#(
    parameter int WIN_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             run,
    output code_t            code,
    output logic             unlock,
    output logic             restart
);

    localparam int WIN_W = $clog2(WIN_CYC + 1);

    logic [WIN_W-1:0] win_q;
    logic             run_q;
    code_t            code_q;

    logic open_req;
    logic stop_req;
    logic win_open;
    logic stop_ok;

    assign open_req = wr_en & is_open_req(wr_data);
    assign stop_req = wr_en & is_stop_req(wr_data);
    assign win_open = (win_q != '0);
    assign stop_ok  = stop_req & win_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= '0;
            run_q  <= 1'b0;
            code_q <= '0;
        end else begin
            if (open_req)
                win_q <= WIN_W'(WIN_CYC);
            else if (stop_ok)
                win_q <= '0;
            else if (win_open)
                win_q <= win_q - 1'b1;

            if (wr_en) begin
                code_q <= wr_data[CODE_W-1:0];
                if (wr_data[RUN_BIT])
                    run_q <= 1'b1;
                else if (win_open)
                    run_q <= 1'b0;
            end
        end
    end

    assign run     = run_q;
    assign code    = code_q;
    assign unlock  = win_open;
    assign restart = wr_en & (wr_data[RUN_BIT] | (wr_data[CODE_W-1:0] != code_q));

    // R7
    run_fall_guard_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(run_q) |-> $past(win_open));

    // R8
    win_bound_chk: assert property (@(posedge clk) disable iff (rst)
        win_q <= WIN_W'(WIN_CYC));

    // R6
    win_reload_chk: assert property (@(posedge clk) disable iff (rst)
        open_req |=> (win_q == WIN_W'(WIN_CYC)));

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter
    import wdt_pkg::*;
#(
    parameter int LOG2_BASE = 11
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  code_t code,
    input  logic  kick,
    input  logic  restart,
    output logic  fire
);

    localparam int CNT_W = LOG2_BASE + (1 << CODE_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] last_val;
    logic             fire_q;
    cnt_act_e         act;

    assign span     = {{CNT_W{1'b0}}, 1'b1} << (LOG2_BASE + int'(code));
    assign last_val = CNT_W'(span - 1'b1);

    always_comb begin
        if (!run || kick || restart)
            act = CNT_CLEAR;
        else if (cnt_q == last_val)
            act = CNT_WRAP;
        else
            act = CNT_STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            unique case (act)
                CNT_CLEAR: cnt_q <= '0;
                CNT_WRAP: begin
                    cnt_q  <= '0;
                    fire_q <= 1'b1;
                end
                default:   cnt_q <= cnt_q + 1'b1;
            endcase
        end
    end

    assign fire = fire_q;

    // R4
    fire_single_chk: assert property (@(posedge clk) disable iff (rst)
        fire_q |=> !fire_q);

    // R9
    fire_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        fire_q |-> $past(run));

    // R5
    kick_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        kick |=> !fire_q);

    // R10
    cnt_in_period_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last_val);

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int LOG2_BASE = 11,
    parameter int WIN_CYC   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             kick,
    output logic [REG_W-1:0] rd_data,
    output logic             wdt_rst
);

    logic       run;
    code_t      code;
    logic       unlock;
    logic       restart;
    ctrl_view_t view;

    wdt_ctrl_regs #(.WIN_CYC(WIN_CYC)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .run     (run),
        .code    (code),
        .unlock  (unlock),
        .restart (restart)
    );

    wdt_tick_counter #(.LOG2_BASE(LOG2_BASE)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .code    (code),
        .kick    (kick),
        .restart (restart),
        .fire    (wdt_rst)
    );

    always_comb begin
        view.unlock = unlock;
        view.run    = run;
        view.code   = code;
    end

    assign rd_data = view;

endmodule

// File: tb/sim_wdt_guard.sv
`timescale 1ns/1ps
module sim_wdt_guard;

    localparam int LB  = 4;
    localparam int WIN = 4;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [4:0] wr_data;
    logic       kick;
    logic [4:0] rd_data;
    logic       wdt_rst;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    // cycle model state
    bit       m_run;
    bit [2:0] m_code;
    int       m_win;
    int       m_cnt;
    bit       m_fire;

    always #10 clk = ~clk;

    wdt_guard #(.LOG2_BASE(LB), .WIN_CYC(WIN)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .kick(kick), .rd_data(rd_data), .wdt_rst(wdt_rst)
    );

    function automatic int period(input bit [2:0] c);
        return 1 << (LB + int'(c));
    endfunction

    function automatic bit [4:0] exp_rd();
        return {bit'(m_win != 0), m_run, m_code};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        m_run = 0; m_code = 0; m_win = 0; m_cnt = 0; m_fire = 0;
    endtask

    task automatic model_step(input bit w, input bit [4:0] d, input bit k);
        bit restart_m;
        bit stop_ok;
        restart_m = w && (d[3] || d[2:0] != m_code);
        m_fire = 0;
        if (!m_run || k || restart_m) m_cnt = 0;
        else if (m_cnt == period(m_code) - 1) begin m_cnt = 0; m_fire = 1; end
        else m_cnt++;
        stop_ok = w && !d[3] && m_win != 0;
        if (w && d[4] && d[3]) m_win = WIN;
        else if (stop_ok) m_win = 0;
        else if (m_win != 0) m_win--;
        if (w) begin
            if (d[3]) m_run = 1;
            else if (stop_ok) m_run = 0;
            m_code = d[2:0];
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic step(input bit w, input bit [4:0] d, input bit k);
        wr_en = w; wr_data = d; kick = k;
        @(posedge clk);
        model_step(w, d, k);
        @(negedge clk);
        wr_en = 0; wr_data = '0; kick = 0;
        cyc++;
        check("R4 pulse vs model", int'(wdt_rst), int'(m_fire));
        check("R2 readback vs model", int'(rd_data), int'(exp_rd()));
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<190000", cyc);
            finish_run();
        end
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            step(0, 5'd0, 0);
            n++;
            if (wdt_rst) break;
        end
    endtask

    task automatic stop_wdt(input bit [2:0] c);
        step(1, {2'b11, c}, 0);
        step(1, {2'b00, c}, 0);
    endtask

    initial begin
        int n;
        int seed;
        bit saw;
        seed = $urandom(1234);
        rst = 1; wr_en = 0; wr_data = '0; kick = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 rd_data after reset", int'(rd_data), 0);
        check("R1 wdt_rst after reset", int'(wdt_rst), 0);

        // R9 stopped: no pulse for a long time
        saw = 0;
        for (int i = 0; i < 600; i++) begin
            step(0, 5'd0, 0);
            if (wdt_rst) saw = 1;
        end
        check("R9 no pulse while stopped", int'(saw), 0);
        step(1, 5'b00111, 0);
        saw = 0;
        for (int i = 0; i < 2100; i++) begin
            step(0, 5'd0, 0);
            if (wdt_rst) saw = 1;
        end
        check("R9 no pulse while stopped, code 7", int'(saw), 0);

        // R3 + R4: each code, two consecutive periods
        for (int c = 0; c < 8; c++) begin
            step(1, {2'b01, 3'(c)}, 0);
            check("R3 run bit after start write", int'(rd_data[3]), 1);
            wait_pulse(n);
            check("R4 first period", n, period(3'(c)));
            wait_pulse(n);
            check("R4 period after wrap", n, period(3'(c)));
            stop_wdt(3'(c));
            check("R6 stopped after sequence", int'(rd_data[3]), 0);
        end

        // R3: start write while running restarts count
        step(1, 5'b01001, 0);
        repeat (20) step(0, 5'd0, 0);
        step(1, 5'b01001, 0);
        wait_pulse(n);
        check("R3 restart by repeated start write", n, period(3'd1));

        // R5: kick restarts the period
        repeat (25) step(0, 5'd0, 0);
        step(0, 5'd0, 1);
        check("R5 no pulse after kick", int'(wdt_rst), 0);
        wait_pulse(n);
        check("R5 full period after kick", n, period(3'd1));

        // R10: code change via ignored stop write restarts with new period
        step(1, 5'b01010, 0);
        repeat (30) step(0, 5'd0, 0);
        step(1, 5'b00001, 0);
        check("R7 run kept by unguarded stop", int'(rd_data[3]), 1);
        check("R10 code updated", int'(rd_data[2:0]), 1);
        wait_pulse(n);
        check("R10 new period from change", n, period(3'd1));
        stop_wdt(3'd1);

        // R6 / R7 / R8: window boundary
        for (int k = 1; k <= 6; k++) begin
            step(1, 5'b01000, 0);
            step(1, 5'b11000, 0);
            check("R8 unlock set by opening write", int'(rd_data[4]), 1);
            for (int j = 1; j < k; j++) begin
                step(0, 5'd0, 0);
                check("R8 unlock while window", int'(rd_data[4]), (j < WIN) ? 1 : 0);
            end
            step(1, 5'b00000, 0);
            if (k <= WIN) begin
                check("R6 stop accepted in window", int'(rd_data[3]), 0);
                check("R8 unlock cleared by stop", int'(rd_data[4]), 0);
            end else begin
                check("R7 stop ignored after window", int'(rd_data[3]), 1);
            end
            stop_wdt(3'd0);
        end
        // R7: stop with no opening write
        step(1, 5'b01000, 0);
        step(1, 5'b00000, 0);
        check("R7 stop ignored without opening", int'(rd_data[3]), 1);
        // R2: unlock bit alone does not open a window
        step(1, 5'b10000, 0);
        step(1, 5'b00000, 0);
        check("R2 unlock without run ignored", int'(rd_data[3]), 1);
        stop_wdt(3'd0);

        // random mix checked against the model every cycle
        for (int i = 0; i < 40000; i++) begin
            int r;
            r = int'($urandom_range(999));
            if (r < 4) begin
                step(1, {2'b01, 3'($urandom_range(3))}, 0);
            end else if (r < 7) begin
                step(1, {2'b11, 3'($urandom_range(3))}, 0);
                repeat ($urandom_range(5)) step(0, 5'd0, 0);
                step(1, {2'b00, 3'($urandom_range(3))}, 0);
            end else if (r < 9) begin
                step(1, 5'($urandom), 0);
            end else if (r < 30) begin
                step(0, 5'd0, 1);
            end else begin
                step(0, 5'd0, 0);
            end
        end

        finish_run();
    end

endmodule